// File: doc/BRIEF.md
# Memory-Mapped Two-Bank Pin Controller

This block is a general-purpose pin controller reached by a processor through an AXI4-Lite slave port. It offers one or two banks of pins. Each bank has a data register and a direction register of its own parameterised width (1 to 32 bits). A direction bit of 1 leaves the pin undriven so it acts as an input; a direction bit of 0 makes the pin an output driven from the data register. Reading a bank's data register returns the synchronised pin level for input bits and the stored value for output bits.

Pin inputs cross into the clock domain through a two-flop synchroniser. An optional interrupt unit records, per bank, that an input-configured bit changed, and raises the interrupt line when the bank's enable bit and the global enable are both set. The second bank and the interrupt unit are each removed by a parameter, and every register bit takes its reset value from a parameter. The slave decodes a 4 KB window.

Top module: `pio_top`

## Requirements
- R1: While reset is held, `b1_out`/`b2_out` equal the data reset parameters, `b1_dir`/`b2_dir` equal the direction reset parameters (truncated to the bank widths), `irq` is 0 and `bvalid`/`rvalid` are 0.
- R2: A write is accepted only in a cycle where `awvalid` and `wvalid` are both high; `bvalid` rises the next cycle, stays high until `bready`, and `bresp` is always 2'b00.
- R3: A read is accepted when `arvalid` is high and no read response is pending; `rvalid` rises the next cycle and holds with a stable `rdata` until `rready`; `rresp` is always 2'b00.
- R4: Word offsets (low 12 address bits, bits 1:0 ignored): 0x000 bank-1 data, 0x004 bank-1 direction, 0x008 bank-2 data, 0x00C bank-2 direction, 0x11C global enable (bit 0), 0x120 change status (bit 0 bank 1, bit 1 bank 2), 0x128 change enable (bit 0 bank 1, bit 1 bank 2). Other offsets read 0 and writes to them change nothing.
- R5: Write strobe bit k updates only register bits 8k+7..8k; other bytes keep their value.
- R6: The direction output of each bank equals its direction register: 1 = input (not driven), 0 = output.
- R7: The pin output of each bank equals its data register; a data read returns the synchronised pin for bits whose direction is 1 and the register bit for bits whose direction is 0.
- R8: A pin change set up before a clock edge can raise `irq` no earlier than the third rising edge; `irq` is still low after the second edge and high after the third when enabled.
- R9: A bank's status bit is set when a synchronised pin bit configured as input changes; bits configured as output never set it. Writing 1 to a status bit clears it, writing 0 leaves it; a change in the same cycle wins over the clear.
- R10: `irq` = global enable AND OR over banks of (status AND enable).
- R11: With the second bank disabled, its registers read 0, `b2_out` is 0 and `b2_dir` is all ones.
- R12: With the interrupt unit disabled, `irq` stays 0 and the global enable, status and enable offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response (always OKAY) |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response (always OKAY) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| b1_in | input | W1 | Bank-1 pin levels |
| b1_out | output | W1 | Bank-1 pin drive values |
| b1_dir | output | W1 | Bank-1 direction, 1 = not driven |
| b2_in | input | W2 | Bank-2 pin levels |
| b2_out | output | W2 | Bank-2 pin drive values |
| b2_dir | output | W2 | Bank-2 direction, 1 = not driven |
| irq | output | 1 | Interrupt request |

## Verification
The hardest behaviour to reach from the ports is the exact cycle in which a pin change becomes an interrupt, because it sits behind three flops and is filtered by the direction register. The bench flips a single pin at a known falling edge and samples `irq` after the second and after the third rising edge, then repeats the flip on a bit switched to output to show it is ignored. A single-bank, interrupt-free copy of the block shares the same bus stimulus, so removed features are checked against a live configuration cycle for cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NREG = 7;

  typedef enum logic [2:0] {
    RG_D1   = 3'd0,
    RG_T1   = 3'd1,
    RG_D2   = 3'd2,
    RG_T2   = 3'd3,
    RG_GIE  = 3'd4,
    RG_ISR  = 3'd5,
    RG_IER  = 3'd6,
    RG_NONE = 3'd7
  } reg_e;

  localparam logic [11:0] OFS_D1  = 12'h000;
  localparam logic [11:0] OFS_T1  = 12'h004;
  localparam logic [11:0] OFS_D2  = 12'h008;
  localparam logic [11:0] OFS_T2  = 12'h00C;
  localparam logic [11:0] OFS_GIE = 12'h11C;
  localparam logic [11:0] OFS_ISR = 12'h120;
  localparam logic [11:0] OFS_IER = 12'h128;

  function automatic reg_e decode(input logic [11:0] a);
    case (a & 12'hFFC)
      OFS_D1:  return RG_D1;
      OFS_T1:  return RG_T1;
      OFS_D2:  return RG_D2;
      OFS_T2:  return RG_T2;
      OFS_GIE: return RG_GIE;
      OFS_ISR: return RG_ISR;
      OFS_IER: return RG_IER;
      default: return RG_NONE;
    endcase
  endfunction

  function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pio_axil.sv
module pio_axil
  import pio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      awaddr,
  input  logic                   awvalid,
  output logic                   awready,
  input  logic                   wvalid,
  output logic                   wready,
  output logic [1:0]             bresp,
  output logic                   bvalid,
  input  logic                   bready,
  input  logic [ADDR_W-1:0]      araddr,
  input  logic                   arvalid,
  output logic                   arready,
  output logic [31:0]            rdata,
  output logic [1:0]             rresp,
  output logic                   rvalid,
  input  logic                   rready,
  input  logic [NREG-1:0][31:0]  rd_vals,
  output logic [NREG-1:0]        wr_sel
);
  logic        bvalid_q, bvalid_d;
  logic        rvalid_q, rvalid_d;
  logic [31:0] rdata_q, rdata_d;
  logic        wr_fire, rd_fire;
  reg_e        wr_idx, rd_idx;

  assign wr_fire = awvalid && wvalid && !bvalid_q;
  assign rd_fire = arvalid && !rvalid_q;
  assign wr_idx  = decode(awaddr[11:0]);
  assign rd_idx  = decode(araddr[11:0]);

  always_comb begin
    for (int i = 0; i < NREG; i++)
      wr_sel[i] = wr_fire && (wr_idx == reg_e'(i));
  end

  always_comb begin
    bvalid_d = bvalid_q;
    if (wr_fire)     bvalid_d = 1'b1;
    else if (bready) bvalid_d = 1'b0;

    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (rd_fire) begin
      rvalid_d = 1'b1;
      rdata_d  = (rd_idx == RG_NONE) ? 32'h0 : rd_vals[rd_idx];
    end else if (rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= 32'h0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign awready = wr_fire;
  assign wready  = wr_fire;
  assign bvalid  = bvalid_q;
  assign bresp   = 2'b00;
  assign arready = !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = 2'b00;
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int          W        = 8,
  parameter bit          PRESENT  = 1'b1,
  parameter logic [31:0] DATA_RST = 32'h0,
  parameter logic [31:0] DIR_RST  = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dat,
  input  logic         wr_dir,
  input  logic [31:0]  wdata,
  input  logic [3:0]   wstrb,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_dir,
  output logic [31:0]  dat_rd,
  output logic [31:0]  dir_rd,
  output logic         chg
);
  if (PRESENT) begin : g_bank
    logic [W-1:0] dat_q, dat_d, dir_q, dir_d;
    logic [W-1:0] s1_q, s2_q, s3_q;
    logic [31:0]  dat_m, dir_m;

    assign dat_m = byte_merge(32'(dat_q), wdata, wstrb);
    assign dir_m = byte_merge(32'(dir_q), wdata, wstrb);

    always_comb begin
      dat_d = dat_q;
      dir_d = dir_q;
      if (wr_dat) dat_d = dat_m[W-1:0];
      if (wr_dir) dir_d = dir_m[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q <= DATA_RST[W-1:0];
        dir_q <= DIR_RST[W-1:0];
        s1_q  <= '0;
        s2_q  <= '0;
        s3_q  <= '0;
      end else begin
        if (wr_dat) dat_q <= dat_d;
        if (wr_dir) dir_q <= dir_d;
        s1_q <= pin_in;
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign pin_out = dat_q;
    assign pin_dir = dir_q;
    assign dat_rd  = 32'((dir_q & s2_q) | (~dir_q & dat_q));
    assign dir_rd  = 32'(dir_q);
    assign chg     = |((s2_q ^ s3_q) & dir_q);
  end else begin : g_absent
    assign pin_out = '0;
    assign pin_dir = '1;
    assign dat_rd  = 32'h0;
    assign dir_rd  = 32'h0;
    assign chg     = 1'b0;
  end
endmodule

// File: rtl/pio_irq.sv
module pio_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chg,
  input  logic       wr_gie,
  input  logic       wr_isr,
  input  logic       wr_ier,
  input  logic [1:0] wbits,
  input  logic       wstrb0,
  output logic       gie,
  output logic [1:0] isr,
  output logic [1:0] ier,
  output logic       irq
);
  logic       gie_q, gie_d;
  logic [1:0] isr_q, isr_d, ier_q, ier_d, clr;

  always_comb begin
    gie_d = gie_q;
    ier_d = ier_q;
    clr   = 2'b00;
    if (wr_gie && wstrb0) gie_d = wbits[0];
    if (wr_ier && wstrb0) ier_d = wbits;
    if (wr_isr && wstrb0) clr   = wbits;
    isr_d = (isr_q & ~clr) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      isr_q <= 2'b00;
      ier_q <= 2'b00;
    end else begin
      gie_q <= gie_d;
      isr_q <= isr_d;
      ier_q <= ier_d;
    end
  end

  assign gie = gie_q;
  assign isr = isr_q;
  assign ier = ier_q;
  assign irq = gie_q && |(isr_q & ier_q);
endmodule

// File: rtl/pio_top.sv
module pio_top
  import pio_pkg::*;
#(
  parameter bit          DUAL    = 1'b1,
  parameter bit          HAS_IRQ = 1'b1,
  parameter int          W1      = 8,
  parameter int          W2      = 12,
  parameter logic [31:0] D1_RST  = 32'h0000_00A5,
  parameter logic [31:0] T1_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] D2_RST  = 32'h0000_0A5A,
  parameter logic [31:0] T2_RST  = 32'h0000_0F0F,
  parameter int          ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [W1-1:0]     b1_in,
  output logic [W1-1:0]     b1_out,
  output logic [W1-1:0]     b1_dir,
  input  logic [W2-1:0]     b2_in,
  output logic [W2-1:0]     b2_out,
  output logic [W2-1:0]     b2_dir,
  output logic              irq
);
  logic [1:0]            rst_sync_q;
  logic                  lrst_n;
  logic [NREG-1:0]       wr_sel;
  logic [NREG-1:0][31:0] rd_vals;
  logic [31:0]           d1_rd, t1_rd, d2_rd, t2_rd;
  logic [1:0]            chg;
  logic                  gie;
  logic [1:0]            isr, ier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign lrst_n = rst_sync_q[1];

  pio_axil #(.ADDR_W(ADDR_W)) axil_i (
    .clk(clk), .rst_n(lrst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .rd_vals(rd_vals), .wr_sel(wr_sel)
  );

  pio_bank #(.W(W1), .PRESENT(1'b1), .DATA_RST(D1_RST), .DIR_RST(T1_RST)) bank1_i (
    .clk(clk), .rst_n(lrst_n),
    .wr_dat(wr_sel[RG_D1]), .wr_dir(wr_sel[RG_T1]),
    .wdata(wdata), .wstrb(wstrb),
    .pin_in(b1_in), .pin_out(b1_out), .pin_dir(b1_dir),
    .dat_rd(d1_rd), .dir_rd(t1_rd), .chg(chg[0])
  );

  pio_bank #(.W(W2), .PRESENT(DUAL), .DATA_RST(D2_RST), .DIR_RST(T2_RST)) bank2_i (
    .clk(clk), .rst_n(lrst_n),
    .wr_dat(wr_sel[RG_D2]), .wr_dir(wr_sel[RG_T2]),
    .wdata(wdata), .wstrb(wstrb),
    .pin_in(b2_in), .pin_out(b2_out), .pin_dir(b2_dir),
    .dat_rd(d2_rd), .dir_rd(t2_rd), .chg(chg[1])
  );

  if (HAS_IRQ) begin : g_irq
    pio_irq irq_i (
      .clk(clk), .rst_n(lrst_n), .chg(chg),
      .wr_gie(wr_sel[RG_GIE]), .wr_isr(wr_sel[RG_ISR]), .wr_ier(wr_sel[RG_IER]),
      .wbits(wdata[1:0]), .wstrb0(wstrb[0]),
      .gie(gie), .isr(isr), .ier(ier), .irq(irq)
    );
  end else begin : g_noirq
    assign gie = 1'b0;
    assign isr = 2'b00;
    assign ier = 2'b00;
    assign irq = 1'b0;
  end

  always_comb begin
    rd_vals         = '0;
    rd_vals[RG_D1]  = d1_rd;
    rd_vals[RG_T1]  = t1_rd;
    rd_vals[RG_D2]  = d2_rd;
    rd_vals[RG_T2]  = t2_rd;
    rd_vals[RG_GIE] = {31'h0, gie};
    rd_vals[RG_ISR] = {30'h0, isr};
    rd_vals[RG_IER] = {30'h0, ier};
  end
endmodule

// File: rtl/pio_chk.sv
module pio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        awvalid,
  input logic        awready,
  input logic        wvalid,
  input logic        wready,
  input logic [1:0]  bresp,
  input logic        bvalid,
  input logic        bready,
  input logic        arready,
  input logic [31:0] rdata,
  input logic [1:0]  rresp,
  input logic        rvalid,
  input logic        rready
);
  // R2
  wr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready) |-> (wvalid && wready));
  // R2
  wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready) |=> bvalid);
  // R2
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  // R2
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00));
  // R3
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (!arready && rresp == 2'b00));
endmodule

bind pio_top pio_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .awvalid(awvalid), .awready(awready), .wvalid(wvalid), .wready(wready),
  .bresp(bresp), .bvalid(bvalid), .bready(bready),
  .arready(arready), .rdata(rdata), .rresp(rresp),
  .rvalid(rvalid), .rready(rready)
);

// File: tb/pio_top_tb_top.sv
module pio_top_tb_top;
  localparam int          W1 = 8;
  localparam int          W2 = 12;
  localparam logic [31:0] D1R = 32'h0000_00A5;
  localparam logic [31:0] T1R = 32'hFFFF_FFFF;
  localparam logic [31:0] D2R = 32'h0000_0A5A;
  localparam logic [31:0] T2R = 32'h0000_0F0F;
  localparam logic [31:0] M1 = 32'h0000_00FF;
  localparam logic [31:0] M2 = 32'h0000_0FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic bready = 1'b1, rready = 1'b1;
  logic [W1-1:0] b1_in = '0;
  logic [W2-1:0] b2_in = '0;

  logic awready, wready, bvalid, arready, rvalid, irq;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [W1-1:0] b1_out, b1_dir;
  logic [W2-1:0] b2_out, b2_dir;

  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, s_irq;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [W1-1:0] s_b1_out, s_b1_dir;
  logic [W2-1:0] s_b2_out, s_b2_dir;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] md1, mt1, md2, mt2;

  always #5 clk = ~clk;

  pio_top #(.DUAL(1'b1), .HAS_IRQ(1'b1), .W1(W1), .W2(W2),
            .D1_RST(D1R), .T1_RST(T1R), .D2_RST(D2R), .T2_RST(T2R)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .b1_in(b1_in), .b1_out(b1_out), .b1_dir(b1_dir),
    .b2_in(b2_in), .b2_out(b2_out), .b2_dir(b2_dir), .irq(irq)
  );

  pio_top #(.DUAL(1'b0), .HAS_IRQ(1'b0), .W1(W1), .W2(W2),
            .D1_RST(D1R), .T1_RST(T1R), .D2_RST(D2R), .T2_RST(T2R)) dut_s_i (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(s_awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(rready),
    .b1_in(b1_in), .b1_out(s_b1_out), .b1_dir(s_b1_dir),
    .b2_in(b2_in), .b2_out(s_b2_out), .b2_dir(s_b2_dir), .irq(s_irq)
  );

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] s);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] view(input logic [31:0] d, input logic [31:0] t,
                                       input logic [31:0] p, input logic [31:0] m);
    return ((t & p) | (~t & d)) & m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    do @(negedge clk); while (!bvalid);
    check("R2 bresp", {30'h0, bresp}, 32'h0);
    awvalid = 1'b0; wvalid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    do @(negedge clk); while (!rvalid);
    d = rdata; ds = s_rdata;
    check("R3 rresp", {30'h0, rresp}, 32'h0);
    arvalid = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, vs, d, t, p;
    logic [3:0] s;
    void'($urandom(32'd4711));

    // R1: reset state
    wait_cyc(3);
    check("R1 b1_out", 32'(b1_out), D1R & M1);
    check("R1 b1_dir", 32'(b1_dir), T1R & M1);
    check("R1 b2_out", 32'(b2_out), D2R & M2);
    check("R1 b2_dir", 32'(b2_dir), T2R & M2);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 valids", {30'h0, bvalid, rvalid}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(4);
    md1 = D1R & M1; mt1 = T1R & M1; md2 = D2R & M2; mt2 = T2R & M2;

    // R2: address without data is not accepted
    @(negedge clk);
    awaddr = 12'h000; wdata = 32'h0000_0011; wstrb = 4'hF; awvalid = 1'b1;
    wait_cyc(3);
    check("R2 no accept on address alone", {30'h0, awready, bvalid}, 32'h0);
    awvalid = 1'b0;
    wait_cyc(1);
    check("R2 data unchanged", 32'(b1_out), md1);

    // R3: response held while rready low
    rready = 1'b0;
    @(negedge clk);
    araddr = 12'h004; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    wait_cyc(3);
    check("R3 rvalid held", {31'h0, rvalid}, 32'h1);
    check("R3 rdata held", rdata, mt1);
    rready = 1'b1;
    wait_cyc(1);
    check("R3 rvalid dropped", {31'h0, rvalid}, 32'h0);

    // R4: unused offsets
    rd(12'h010, v, vs); check("R4 unused 0x010", v, 32'h0);
    rd(12'h124, v, vs); check("R4 unused 0x124", v, 32'h0);
    rd(12'hFFC, v, vs); check("R4 unused 0xFFC", v, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF, 4'hF);
    wr(12'h200, 32'hFFFF_FFFF, 4'hF);
    check("R4 unused write b1_out", 32'(b1_out), md1);
    check("R4 unused write b2_out", 32'(b2_out), md2);
    check("R4 unused write b2_dir", 32'(b2_dir), mt2);

    // R5: directed byte strobe on bank 2
    wr(12'h008, 32'h0000_0ABC, 4'hF); md2 = 32'hABC;
    wr(12'h008, 32'h0000_05FF, 4'b0010); md2 = 32'h5BC;
    check("R5 strobe lane 1 only", 32'(b2_out), md2);

    // R6 R7 R11: random data, direction and pins
    for (int it = 0; it < 60; it++) begin
      d = $urandom; t = $urandom; s = 4'($urandom);
      if (it % 2 == 0) begin
        wr(12'h000, d, s); md1 = merge(md1, d, s) & M1;
        wr(12'h004, t, 4'hF); mt1 = t & M1;
      end else begin
        wr(12'h008, d, s); md2 = merge(md2, d, s) & M2;
        wr(12'h00C, t, 4'hF); mt2 = t & M2;
      end
      p = $urandom;
      @(negedge clk);
      b1_in = p[W1-1:0]; b2_in = p[16 +: W2];
      wait_cyc(3);
      check("R6 b1_dir", 32'(b1_dir), mt1);
      check("R6 b2_dir", 32'(b2_dir), mt2);
      check("R7 b1_out", 32'(b1_out), md1);
      check("R7 b2_out", 32'(b2_out), md2);
      rd(12'h000, v, vs);
      check("R7 bank1 read", v, view(md1, mt1, 32'(b1_in), M1));
      check("R7 single cfg bank1 read", vs, view(md1, mt1, 32'(b1_in), M1));
      rd(12'h008, v, vs);
      check("R7 bank2 read", v, view(md2, mt2, 32'(b2_in), M2));
      check("R11 bank2 absent data read", vs, 32'h0);
      rd(12'h00C, v, vs);
      check("R6 bank2 dir read", v, mt2);
      check("R11 bank2 absent dir read", vs, 32'h0);
      check("R11 b2_out", 32'(s_b2_out), 32'h0);
      check("R11 b2_dir", 32'(s_b2_dir), M2);
    end

    // Interrupt sequence
    wr(12'h004, 32'hFF, 4'hF); mt1 = 32'hFF;
    wr(12'h00C, 32'h000, 4'hF); mt2 = 32'h0;
    @(negedge clk); b1_in = '0; b2_in = '0;
    wait_cyc(4);
    wr(12'h120, 32'h3, 4'hF);
    rd(12'h120, v, vs); check("R9 status cleared", v, 32'h0);
    wr(12'h128, 32'h1, 4'hF);
    wr(12'h11C, 32'h1, 4'hF);
    check("R10 irq low with status clear", {31'h0, irq}, 32'h0);
    // R8: flip one input pin and count edges
    @(negedge clk); b1_in[0] = 1'b1;
    wait_cyc(2);
    check("R8 irq low after two edges", {31'h0, irq}, 32'h0);
    wait_cyc(1);
    check("R8 irq high after third edge", {31'h0, irq}, 32'h1);
    check("R12 no irq without unit", {31'h0, s_irq}, 32'h0);
    rd(12'h120, v, vs);
    check("R9 bank1 status set", v, 32'h1);
    check("R12 status reads zero", vs, 32'h0);
    rd(12'h11C, v, vs);
    check("R4 global enable readback", v, 32'h1);
    check("R12 global enable reads zero", vs, 32'h0);
    rd(12'h128, v, vs);
    check("R4 enable readback", v, 32'h1);
    check("R12 enable reads zero", vs, 32'h0);
    wr(12'h128, 32'h0, 4'hF);
    check("R10 irq masked by bank enable", {31'h0, irq}, 32'h0);
    wr(12'h128, 32'h1, 4'hF);
    check("R10 irq back with bank enable", {31'h0, irq}, 32'h1);
    wr(12'h11C, 32'h0, 4'hF);
    check("R10 irq masked by global enable", {31'h0, irq}, 32'h0);
    wr(12'h11C, 32'h1, 4'hF);
    wr(12'h120, 32'h1, 4'h0);
    check("R5 clear without strobe ignored", {31'h0, irq}, 32'h1);
    wr(12'h120, 32'h2, 4'hF);
    check("R9 writing other bit keeps status", {31'h0, irq}, 32'h1);
    wr(12'h120, 32'h1, 4'hF);
    check("R9 write one clears", {31'h0, irq}, 32'h0);
    // R9: output-configured bit does not set status
    wr(12'h004, 32'hFD, 4'hF); mt1 = 32'hFD;
    @(negedge clk); b1_in[1] = 1'b1;
    wait_cyc(4);
    rd(12'h120, v, vs); check("R9 output bit change ignored", v, 32'h0);
    // R9 R10: bank 2 change with its enable off
    wr(12'h00C, 32'h001, 4'hF); mt2 = 32'h1;
    @(negedge clk); b2_in[0] = 1'b1;
    wait_cyc(4);
    rd(12'h120, v, vs); check("R9 bank2 status set", v, 32'h2);
    check("R10 irq low, bank2 not enabled", {31'h0, irq}, 32'h0);
    wr(12'h128, 32'h2, 4'hF);
    check("R10 irq high, bank2 enabled", {31'h0, irq}, 32'h1);

    finish_run();
  end
endmodule